// File: doc/BRIEF.md
# Timekeeper with Alarm and Hourly Chime

This block keeps the time of day as three BCD digit pairs (hours, minutes, seconds) and a separate alarm setting of hours and minutes. All state runs on the system clock. A parameterised divider produces a one-cycle enable once per second, and the counting chain advances on that enable. A single active-low synchronous reset clears the running time and the alarm together.

Setting is done with a push button. While the set-mode input is high, the running time is frozen. Each press of the increment button steps one selected field by one, either in the running time or in the alarm. The step wraps with the same modulus as normal counting but never carries into the next field. With set mode low, a comparator flags a match between the running hours and minutes and the alarm hours and minutes. Separately, a chime flag is raised for the first few seconds of every whole hour. The buzzer request is the OR of the two flags. Display scanning and tone generation are left to other blocks.

Top module: `alarm_clock_core`

## Requirements
- R1: While rst_n is 0 at a rising clock edge, every time and alarm digit becomes 0, the second divider restarts and the button history is cleared.
- R2: Seconds and minutes are BCD pairs (tens in bits 7:4, units in bits 3:0) counting 00 to 59 and then 00. Hours count 00 to 23 and then 00.
- R3: With set_mode at 0, seconds advance by one at every CLK_DIV-th rising edge counted from the end of reset. The first advance comes at the CLK_DIV-th edge after rst_n returns to 1.
- R4: With set_mode at 0, the minute advances in the same edge as seconds wrap from 59 to 00. The hour advances in the same edge as minutes wrap from 59 to 00.
- R5: While set_mode is 1, the divider keeps running but its enable does not change the time.
- R6: While set_mode is 1, one rising edge of inc_btn steps exactly one field by one. The change appears at the third rising clock edge after the button input rises. set_alarm selects the target: 0 for the running time, 1 for the alarm. set_field selects the field: 00 seconds, 01 minutes, 10 hours. The step wraps like R2 and never carries.
- R7: A press has no effect when set_mode is 0, when set_field is 11, or when the alarm target is selected together with seconds.
- R8: alarm_hit is 1 exactly when set_mode is 0 and the running hours and minutes equal the alarm hours and minutes.
- R9: chime is 1 exactly when set_mode is 0, the minutes are 00 and the seconds are below CHIME_SECS.
- R10: buzz equals alarm_hit OR chime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_mode | input | 1 | 1 freezes the time and enables button setting |
| set_alarm | input | 1 | Setting target: 0 running time, 1 alarm |
| set_field | input | 2 | Field: 00 seconds, 01 minutes, 10 hours, 11 none |
| inc_btn | input | 1 | Increment button, asynchronous level |
| time_hh | output | 8 | Running hours, BCD |
| time_mm | output | 8 | Running minutes, BCD |
| time_ss | output | 8 | Running seconds, BCD |
| alarm_hh | output | 8 | Alarm hours, BCD |
| alarm_mm | output | 8 | Alarm minutes, BCD |
| alarm_hit | output | 1 | Time matches alarm |
| chime | output | 1 | Start-of-hour chime window |
| buzz | output | 1 | Buzzer request |

## Verification
The hardest case to reach from the ports is the chained rollover from 23:59:59 to 00:00:00. Seconds, minutes and hours all wrap in one edge, and the chime window opens in that same edge. Letting the clock run into it would take a full simulated day. Instead, the bench presses its way in set mode to 23:59:50, leaves set mode and lets the short divider carry it across. A model of the requirements kept in the bench is compared against every output on every cycle. That comparison continues through constrained-random button, field and mode activity afterwards.

// File: rtl/alarm_clock_pkg.sv
// Shared types and helpers for the timekeeper.
package alarm_clock_pkg;

    // Field selector encoding used by set_field.
    typedef enum logic [1:0] {
        FLD_SEC  = 2'b00,
        FLD_MIN  = 2'b01,
        FLD_HR   = 2'b10,
        FLD_NONE = 2'b11
    } field_t;

    // Converts a two-digit BCD byte to its binary value.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

endpackage

// File: rtl/sec_tick_gen.sv
// Divides the system clock into a one-cycle enable every DIV cycles.
// Assumes DIV >= 2; the enable is never used as a clock.
module sec_tick_gen #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R3: the enable never lasts two cycles
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/btn_edge.sv
// Synchronises an asynchronous button level and emits one pulse per rising edge.
// Assumes the button is debounced upstream.
module btn_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic pulse
);
    logic [2:0] sh;

    assign pulse = sh[1] & ~sh[2];

    // Two-stage synchroniser followed by a history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], btn};
    end

    // R6: one press yields one pulse
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/bcd_mod_counter.sv
// Two-digit BCD counter with modulus MOD (at most 100).
// wrap is high in the cycle in which a step returns the value to 00.
module bcd_mod_counter #(
    parameter int MOD = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [7:0] val,
    output logic       wrap
);
    localparam logic [3:0] LT = 4'((MOD - 1) / 10);
    localparam logic [3:0] LU = 4'((MOD - 1) % 10);

    logic at_last;

    assign at_last = (val[7:4] == LT) && (val[3:0] == LU);
    assign wrap    = step && at_last;

    // Steps the BCD pair, wrapping to 00 after MOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                 val <= '0;
        else if (step) begin
            if (at_last)            val <= '0;
            else if (val[3:0] == 4'd9) val <= {val[7:4] + 4'd1, 4'd0};
            else                    val <= {val[7:4], val[3:0] + 4'd1};
        end
    end

    // R2: the pair stays a legal value below MOD
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (val[3:0] <= 4'd9) && ((val[7:4] < LT) || (val[7:4] == LT && val[3:0] <= LU)));
    // R2: a step from the last value returns to zero
    a_r2_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (val == 8'h00));
endmodule

// File: rtl/alarm_clock_core.sv
// Time-of-day keeper with a settable alarm and an hourly chime.
// Assumes inc_btn is debounced; set inputs are stable around a press.
module alarm_clock_core
    import alarm_clock_pkg::*;
#(
    parameter int CLK_DIV    = 50_000_000,
    parameter int CHIME_SECS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_mode,
    input  logic       set_alarm,
    input  logic [1:0] set_field,
    input  logic       inc_btn,
    output logic [7:0] time_hh,
    output logic [7:0] time_mm,
    output logic [7:0] time_ss,
    output logic [7:0] alarm_hh,
    output logic [7:0] alarm_mm,
    output logic       alarm_hit,
    output logic       chime,
    output logic       buzz
);
    localparam logic [6:0] CHIME_LIM = 7'(CHIME_SECS);

    logic   tick, press;
    logic   ss_wrap, mm_wrap, hh_wrap, amm_wrap, ahh_wrap;
    logic   ss_step, mm_step, hh_step, amm_step, ahh_step;
    logic   t_press, a_press;
    field_t fld;

    assign fld     = field_t'(set_field);
    assign t_press = set_mode && press && !set_alarm;
    assign a_press = set_mode && press &&  set_alarm;

    sec_tick_gen #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));
    btn_edge u_btn (.clk(clk), .rst_n(rst_n), .btn(inc_btn), .pulse(press));

    // Step sources: enable chain when running, button when setting.
    always_comb begin
        ss_step  = set_mode ? (t_press && fld == FLD_SEC) : tick;
        mm_step  = set_mode ? (t_press && fld == FLD_MIN) : ss_wrap;
        hh_step  = set_mode ? (t_press && fld == FLD_HR)  : mm_wrap;
        amm_step = a_press && fld == FLD_MIN;
        ahh_step = a_press && fld == FLD_HR;
    end

    bcd_mod_counter #(.MOD(60)) u_ss  (.clk(clk), .rst_n(rst_n), .step(ss_step),  .val(time_ss),  .wrap(ss_wrap));
    bcd_mod_counter #(.MOD(60)) u_mm  (.clk(clk), .rst_n(rst_n), .step(mm_step),  .val(time_mm),  .wrap(mm_wrap));
    bcd_mod_counter #(.MOD(24)) u_hh  (.clk(clk), .rst_n(rst_n), .step(hh_step),  .val(time_hh),  .wrap(hh_wrap));
    bcd_mod_counter #(.MOD(60)) u_amm (.clk(clk), .rst_n(rst_n), .step(amm_step), .val(alarm_mm), .wrap(amm_wrap));
    bcd_mod_counter #(.MOD(24)) u_ahh (.clk(clk), .rst_n(rst_n), .step(ahh_step), .val(alarm_hh), .wrap(ahh_wrap));

    // Match and chime flags, both masked during setting.
    always_comb begin
        alarm_hit = !set_mode && (time_hh == alarm_hh) && (time_mm == alarm_mm);
        chime     = !set_mode && (time_mm == 8'h00) && (bcd_to_bin(time_ss) < CHIME_LIM);
        buzz      = alarm_hit || chime;
    end

    // R4: seconds wrap carries into minutes in the same edge
    a_r4_min_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_mode && tick && time_ss == 8'h59 && time_mm != 8'h59) |=> (time_mm == $past(time_mm) + 8'h01 || time_mm[3:0] == 4'h0));
    // R5: frozen while setting unless a press arrives
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !press) |=> ($stable(time_ss) && $stable(time_mm) && $stable(time_hh)));
    // R7: alarm untouched outside set mode
    a_r7_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set_mode |=> ($stable(alarm_hh) && $stable(alarm_mm)));
endmodule

// File: tb/tb_alarm_clock_core.sv
// Bench: requirement model compared every cycle, directed corners plus seeded random.
module tb_alarm_clock_core;
    localparam int DIV   = 4;
    localparam int CHIME = 5;

    logic       clk = 0, rst_n = 0, set_mode = 0, set_alarm = 0, inc_btn = 0;
    logic [1:0] set_field = 2'b11;
    logic [7:0] time_hh, time_mm, time_ss, alarm_hh, alarm_mm;
    logic       alarm_hit, chime, buzz;

    int checks = 0, errors = 0;
    int seed_dummy;

    alarm_clock_core #(.CLK_DIV(DIV), .CHIME_SECS(CHIME)) dut (
        .clk(clk), .rst_n(rst_n), .set_mode(set_mode), .set_alarm(set_alarm),
        .set_field(set_field), .inc_btn(inc_btn), .time_hh(time_hh), .time_mm(time_mm),
        .time_ss(time_ss), .alarm_hh(alarm_hh), .alarm_mm(alarm_mm),
        .alarm_hit(alarm_hit), .chime(chime), .buzz(buzz));

    always #2 clk = ~clk;

    // Model state
    logic [7:0] m_hh, m_mm, m_ss, m_ahh, m_amm;
    int         m_div;
    logic [2:0] m_sh;

    function automatic logic [7:0] nxt(input logic [7:0] v, input int md);
        int b;
        b = (v[7:4] * 10 + v[3:0] + 1) % md;
        return {4'(b / 10), 4'(b % 10)};
    endfunction

    // Model of R1..R7 updated at every edge from the inputs only.
    always @(posedge clk) begin
        logic tk, pr, sw, mw;
        if (!rst_n) begin
            m_hh = 0; m_mm = 0; m_ss = 0; m_ahh = 0; m_amm = 0; m_div = 0; m_sh = 0;
        end else begin
            tk = (m_div == DIV - 1);
            pr = m_sh[1] & ~m_sh[2];
            m_div = tk ? 0 : m_div + 1;
            m_sh  = {m_sh[1:0], inc_btn};
            if (!set_mode) begin
                if (tk) begin
                    sw = (m_ss == 8'h59); mw = (m_mm == 8'h59);
                    m_ss = nxt(m_ss, 60);
                    if (sw) begin
                        m_mm = nxt(m_mm, 60);
                        if (mw) m_hh = nxt(m_hh, 24);
                    end
                end
            end else if (pr) begin
                if (!set_alarm) begin
                    if (set_field == 2'b00) m_ss = nxt(m_ss, 60);
                    if (set_field == 2'b01) m_mm = nxt(m_mm, 60);
                    if (set_field == 2'b10) m_hh = nxt(m_hh, 24);
                end else begin
                    if (set_field == 2'b01) m_amm = nxt(m_amm, 60);
                    if (set_field == 2'b10) m_ahh = nxt(m_ahh, 24);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison at the falling edge.
    bit compare_on = 0;
    always @(negedge clk) if (compare_on) begin
        logic eh, ec;
        eh = !set_mode && m_hh == m_ahh && m_mm == m_amm;
        ec = !set_mode && m_mm == 8'h00 && (m_ss[7:4] * 10 + m_ss[3:0]) < CHIME;
        chk("R2/R3/R4 seconds", time_ss, m_ss);
        chk("R2/R4 minutes", time_mm, m_mm);
        chk("R2/R4 hours", time_hh, m_hh);
        chk("R6/R7 alarm minutes", alarm_mm, m_amm);
        chk("R6/R7 alarm hours", alarm_hh, m_ahh);
        chk("R8 alarm_hit", 8'(alarm_hit), 8'(eh));
        chk("R9 chime", 8'(chime), 8'(ec));
        chk("R10 buzz", 8'(buzz), 8'(eh | ec));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic tgt, input logic [1:0] f, input int n);
        set_alarm = tgt; set_field = f;
        for (int i = 0; i < n; i++) begin
            inc_btn = 1; cyc(4); inc_btn = 0; cyc(4);
        end
    endtask

    // Watchdog
    initial begin
        #700000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(1234);
        cyc(3);
        compare_on = 1;
        // R1: reset state
        chk("R1 reset seconds", time_ss, 8'h00);
        chk("R1 reset alarm", alarm_hh, 8'h00);
        rst_n = 1;
        // R3: first advance at the DIV-th edge after release
        @(negedge clk);
        cyc(DIV - 2); chk("R3 before first tick", time_ss, 8'h00);
        cyc(1);       chk("R3 first tick", time_ss, 8'h01);
        cyc(40 * DIV);
        // R5 and R6: set to 23:59:50 while frozen
        set_mode = 1;
        press(0, 2'b10, 23 - int'(time_hh[7:4]) * 10 - int'(time_hh[3:0]));
        press(0, 2'b01, 59 - int'(time_mm[7:4]) * 10 - int'(time_mm[3:0]));
        press(0, 2'b00, (110 - int'(time_ss[7:4]) * 10 - int'(time_ss[3:0])) % 60);
        chk("R6 set hours", time_hh, 8'h23);
        chk("R6 set seconds", time_ss, 8'h50);
        cyc(5 * DIV);
        chk("R5 frozen", time_ss, 8'h50);
        // R7: ignored presses
        press(1, 2'b00, 2);
        press(0, 2'b11, 2);
        chk("R7 none field", time_ss, 8'h50);
        // R6: alarm to 00:01
        press(1, 2'b01, 1);
        chk("R6 alarm minute", alarm_mm, 8'h01);
        set_mode = 0;
        cyc(12 * DIV);
        chk("R4 midnight rollover hours", time_hh, 8'h00);
        chk("R9 chime at hour", 8'(chime), 8'h1);
        cyc(60 * DIV);
        chk("R8 alarm at 00:01", 8'(alarm_hit), 8'h1);
        // R7: press outside set mode
        press(1, 2'b01, 2);
        chk("R7 run-mode press", alarm_mm, 8'h01);
        // Random phase
        for (int k = 0; k < 400; k++) begin
            set_mode  = ($urandom % 4) != 0;
            set_alarm = $urandom % 2;
            set_field = 2'($urandom % 4);
            if ($urandom % 2) begin inc_btn = 1; cyc(1 + $urandom % 5); inc_btn = 0; end
            cyc(1 + $urandom % 12);
        end
        // R1: reset mid-operation
        rst_n = 0; cyc(2);
        chk("R1 reset minutes", time_mm, 8'h00);
        chk("R1 reset alarm minutes", alarm_mm, 8'h00);
        rst_n = 1; set_mode = 0; cyc(20);
        compare_on = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule